// File: doc/BRIEF.md
# Aggregated Bit-Vector Rule Intersector

This block is the back end of a multi-field packet classifier. Each header field has already been looked up elsewhere and reduced to a small key. For every field the block holds a table of rule vectors indexed by that key: bit i of a vector is 1 when rule i accepts that field value. A rule matches the whole header only if its bit is 1 in the vector of every field. Rules are ranked so that a lower index wins, which makes the best rule the lowest set bit of the intersection.

The block does not read the full vectors blindly. With each stored vector it keeps a coarse summary that has one bit per block of `BLOCK` rules, and that bit is the OR of the block. When a search starts, the summaries of all fields are ANDed in one cycle. Blocks whose summary bit is then 0 cannot hold a match and are never fetched. The candidate blocks are visited in ascending order, one word per field per cycle. A candidate can still come out empty, since two fields may set different bits of the same block, and the walk then moves on. It stops at the first block whose intersection is nonzero. The block also reports the number of word fetches it made, so the cost of a search can be seen directly.

Vectors are loaded through a write port one whole vector at a time, and the summary is derived as the vector is written.

Top module: `abv_intersector`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `match_o`, `rule_o` and `access_o` are all 0. Every stored vector reads as all zeros.
- R2: A write with `wr_en_i` high replaces the whole vector held for field `wr_field_i` at key `wr_key_i` with `wr_vec_i`, and updates its summary. Summary bit b is the OR of vector bits b*BLOCK to b*BLOCK+BLOCK-1. Later searches use the new contents.
- R3: A search uses the key for field f from `key_i[f*KEY_W +: KEY_W]`. When the AND of the selected vectors is nonzero, the finishing `done_o` cycle shows `match_o`=1 and `rule_o` set to the index of the lowest set bit of that AND.
- R4: Each visited block costs NUM_FIELDS word fetches, and blocks whose ANDed summary bit is 0 cost nothing. `access_o` is cleared when a search is accepted and at done equals NUM_FIELDS times the number of blocks visited.
- R5: Candidate blocks are visited in ascending order at one block per cycle. If the hit is the j-th candidate, `done_o` is high j cycles after the clock edge that accepted `start_i`. `done_o` is a one-cycle pulse and falls together with `busy_o`.
- R6: A candidate block whose intersection is zero does not end the search. The walk continues with the next candidate.
- R7: When no candidate block has a nonzero intersection, `done_o` shows `match_o`=0 and `rule_o`=0. With c candidate blocks this happens c+1 cycles after the accepting edge, and `access_o` is NUM_FIELDS*c. With no candidates that is 1 cycle and 0 fetches.
- R8: `busy_o` is high from the edge that accepts `start_i` until the edge that raises `done_o`. A `start_i` seen while `busy_o` is high is ignored and changes neither that search's result nor its timing.
- R9: `match_o`, `rule_o` and `access_o` hold their values from `done_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write one rule vector |
| wr_field_i | input | FLD_W (1) | Field whose table is written |
| wr_key_i | input | KEY_W (3) | Key of the vector written |
| wr_vec_i | input | NUM_RULES (64) | New rule vector |
| start_i | input | 1 | Start a search (taken only when idle) |
| key_i | input | NUM_FIELDS*KEY_W (6) | Per-field lookup keys, field f at bits f*KEY_W |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| match_o | output | 1 | A rule matched every field |
| rule_o | output | RULE_W (6) | Best (lowest) matching rule index |
| access_o | output | ACC_W (5) | Word fetches made by the last search |

## Verification
The bench goes after false candidates: blocks where every field sets some bit but no bit is common to all fields. A design that stopped at the first candidate would report a miss or a wrong rule on these, and one that skipped the word compare would report a rule that is absent from one of the fields. Fetch counts and done latency are checked for hits in a late block, for searches with no candidates, and for a walk through all eight candidates that ends empty. A design that fetched every block, or failed to skip non-candidates, would show too large a count and too long a delay. The bench also checks the highest rule index, that a vector rewrite replaces the old contents, that a start issued mid-search is ignored (a restart would change the latency or the result), and that results hold after done.

// File: rtl/abv_pkg.sv
package abv_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } abv_state_e;
endpackage

// File: rtl/abv_field_store.sv
// Rule-vector table for one header field, with a per-block OR summary
// derived at write time.
module abv_field_store #(
    parameter int NUM_RULES = 64,
    parameter int BLOCK     = 8,
    parameter int KEY_W     = 3
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_en_i,
    input  logic [KEY_W-1:0]              wr_key_i,
    input  logic [NUM_RULES-1:0]          wr_vec_i,
    input  logic [KEY_W-1:0]              agg_key_i,
    output logic [NUM_RULES/BLOCK-1:0]    agg_o,
    input  logic [KEY_W-1:0]              word_key_i,
    input  logic [$clog2(NUM_RULES/BLOCK)-1:0] word_blk_i,
    output logic [BLOCK-1:0]              word_o
);
    localparam int NBLK  = NUM_RULES / BLOCK;
    localparam int DEPTH = 1 << KEY_W;

    logic [NUM_RULES-1:0] vec_d [DEPTH];
    logic [NUM_RULES-1:0] vec_q [DEPTH];
    logic [NBLK-1:0]      sum_d [DEPTH];
    logic [NBLK-1:0]      sum_q [DEPTH];
    logic [NBLK-1:0]      wr_sum;

    for (genvar b = 0; b < NBLK; b++) begin : g_sum
        assign wr_sum[b] = |wr_vec_i[b*BLOCK +: BLOCK];
    end

    always_comb begin
        vec_d = vec_q;
        sum_d = sum_q;
        if (wr_en_i) begin
            vec_d[wr_key_i] = wr_vec_i;
            sum_d[wr_key_i] = wr_sum;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int k = 0; k < DEPTH; k++) begin
                vec_q[k] <= '0;
                sum_q[k] <= '0;
            end
        end else begin
            vec_q <= vec_d;
            sum_q <= sum_d;
        end
    end

    assign agg_o  = sum_q[agg_key_i];
    assign word_o = vec_q[word_key_i][word_blk_i*BLOCK +: BLOCK];
endmodule

// File: rtl/abv_first_set.sv
// Lowest set bit finder.
module abv_first_set #(
    parameter int W = 8
) (
    input  logic [W-1:0]         vec_i,
    output logic                 found_o,
    output logic [$clog2(W)-1:0] idx_o
);
    localparam int IDX_W = $clog2(W);

    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/abv_intersector.sv
// Multi-field rule intersector: ANDs per-block summaries, then fetches
// and ANDs only candidate blocks in ascending order, stopping at the first hit.
module abv_intersector
    import abv_pkg::*;
#(
    parameter int NUM_FIELDS = 2,
    parameter int NUM_RULES  = 64,
    parameter int BLOCK      = 8,
    parameter int KEY_W      = 3,
    localparam int NBLK      = NUM_RULES / BLOCK,
    localparam int BLK_W     = $clog2(NBLK),
    localparam int OFF_W     = $clog2(BLOCK),
    localparam int RULE_W    = $clog2(NUM_RULES),
    localparam int ACC_W     = $clog2(NBLK * NUM_FIELDS + 1),
    localparam int FLD_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_en_i,
    input  logic [FLD_W-1:0]            wr_field_i,
    input  logic [KEY_W-1:0]            wr_key_i,
    input  logic [NUM_RULES-1:0]        wr_vec_i,
    input  logic                        start_i,
    input  logic [NUM_FIELDS*KEY_W-1:0] key_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        match_o,
    output logic [RULE_W-1:0]           rule_o,
    output logic [ACC_W-1:0]            access_o
);
    typedef struct packed {
        abv_state_e                  st;
        logic [NUM_FIELDS*KEY_W-1:0] key;
        logic [NBLK-1:0]             cand;
        logic                        done;
        logic                        match;
        logic [RULE_W-1:0]           rule;
        logic [ACC_W-1:0]            acc;
    } abv_regs_t;

    abv_regs_t r_d, r_q;

    logic [NBLK-1:0]  agg_f  [NUM_FIELDS];
    logic [BLOCK-1:0] word_f [NUM_FIELDS];
    logic [NBLK-1:0]  agg_and;
    logic [BLOCK-1:0] word_and;
    logic             cand_found;
    logic [BLK_W-1:0] blk_idx;
    logic             word_found;
    logic [OFF_W-1:0] off_idx;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        abv_field_store #(
            .NUM_RULES (NUM_RULES),
            .BLOCK     (BLOCK),
            .KEY_W     (KEY_W)
        ) u_store (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .wr_en_i    (wr_en_i && (wr_field_i == FLD_W'(f))),
            .wr_key_i   (wr_key_i),
            .wr_vec_i   (wr_vec_i),
            .agg_key_i  (key_i[f*KEY_W +: KEY_W]),
            .agg_o      (agg_f[f]),
            .word_key_i (r_q.key[f*KEY_W +: KEY_W]),
            .word_blk_i (blk_idx),
            .word_o     (word_f[f])
        );
    end

    always_comb begin
        agg_and  = '1;
        word_and = '1;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            agg_and  = agg_and & agg_f[f];
            word_and = word_and & word_f[f];
        end
    end

    abv_first_set #(.W(NBLK)) u_blk_pick (
        .vec_i   (r_q.cand),
        .found_o (cand_found),
        .idx_o   (blk_idx)
    );

    abv_first_set #(.W(BLOCK)) u_bit_pick (
        .vec_i   (word_and),
        .found_o (word_found),
        .idx_o   (off_idx)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_SCAN;
                    r_d.key   = key_i;
                    r_d.cand  = agg_and;
                    r_d.acc   = '0;
                    r_d.match = 1'b0;
                    r_d.rule  = '0;
                end
            end
            ST_SCAN: begin
                if (!cand_found) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.acc = r_q.acc + ACC_W'(NUM_FIELDS);
                    if (word_found) begin
                        r_d.st    = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.match = 1'b1;
                        r_d.rule  = {blk_idx, off_idx};
                    end else begin
                        r_d.cand[blk_idx] = 1'b0;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o   = (r_q.st == ST_SCAN);
    assign done_o   = r_q.done;
    assign match_o  = r_q.match;
    assign rule_o   = r_q.rule;
    assign access_o = r_q.acc;
endmodule

// File: rtl/abv_intersector_chk.sv
module abv_intersector_chk #(
    parameter int NUM_FIELDS = 2,
    parameter int RULE_W     = 6,
    parameter int ACC_W      = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              match_o,
    input logic [RULE_W-1:0] rule_o,
    input logic [ACC_W-1:0]  access_o
);
    // R5
    done_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

    // R5
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    miss_rule_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !match_o) |-> (rule_o == '0));

    // R4
    access_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> ((access_o == $past(access_o)) ||
                    (access_o == $past(access_o) + ACC_W'(NUM_FIELDS))));

    // R4
    access_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> ((access_o == '0) && !match_o));

    // R9
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> ($stable(rule_o) && $stable(match_o) && $stable(access_o)));
endmodule

bind abv_intersector abv_intersector_chk #(
    .NUM_FIELDS (NUM_FIELDS),
    .RULE_W     (RULE_W),
    .ACC_W      (ACC_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .match_o  (match_o),
    .rule_o   (rule_o),
    .access_o (access_o)
);

// File: tb/tb_abv_intersector.sv
module tb_abv_intersector;
    localparam int NF    = 2;
    localparam int NR    = 64;
    localparam int BLK   = 8;
    localparam int KW    = 3;
    localparam int NBLK  = NR / BLK;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [0:0]    wr_field = '0;
    logic [KW-1:0] wr_key = '0;
    logic [NR-1:0] wr_vec = '0;
    logic          start = 1'b0;
    logic [NF*KW-1:0] key = '0;
    logic          busy, done, match;
    logic [5:0]    rule;
    logic [4:0]    access;

    abv_intersector dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_field_i(wr_field),
        .wr_key_i(wr_key), .wr_vec_i(wr_vec), .start_i(start), .key_i(key),
        .busy_o(busy), .done_o(done), .match_o(match), .rule_o(rule), .access_o(access)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int failures = 0;
    logic [NR-1:0] model [NF][8];

    int    exp_m_q[$], exp_r_q[$], exp_a_q[$], exp_l_q[$], st_q[$];
    string tag_q[$];
    int    last_m = 0, last_r = 0, last_a = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int f, int k, logic [NR-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_field = f[0:0]; wr_key = k[KW-1:0]; wr_vec = v;
        @(negedge clk);
        wr_en = 1'b0;
        model[f][k] = v;
    endtask

    task automatic launch(int k0, int k1, string tag);
        logic [NR-1:0] a, b;
        int j, hit, r;
        a = model[0][k0]; b = model[1][k1];
        j = 0; hit = 0; r = 0;
        for (int blk = 0; blk < NBLK; blk++) begin
            if (!hit && (|a[blk*BLK +: BLK]) && (|b[blk*BLK +: BLK])) begin
                j++;
                for (int i = BLK - 1; i >= 0; i--)
                    if (a[blk*BLK+i] && b[blk*BLK+i]) begin hit = 1; r = blk*BLK + i; end
            end
        end
        exp_m_q.push_back(hit);
        exp_r_q.push_back(r);
        exp_a_q.push_back(NF * j);
        exp_l_q.push_back(hit ? j : j + 1);
        tag_q.push_back(tag);
        @(negedge clk);
        key = {k1[KW-1:0], k0[KW-1:0]};
        start = 1'b1;
        st_q.push_back(cyc + 1);
        @(negedge clk);
        start = 1'b0;
        check({tag, " R8 busy after start"}, int'(busy), 1);
    endtask

    task automatic wait_done();
        while (exp_m_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic search(int k0, int k1, string tag);
        launch(k0, k1, tag);
        wait_done();
    endtask

    // monitor: pop expected item at each done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (exp_m_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R8 unexpected done actual=1 expected=0");
                end else begin
                    automatic string t = tag_q.pop_front();
                    check({t, " R3 match"}, int'(match), exp_m_q.pop_front());
                    check({t, " R3 rule"}, int'(rule), exp_r_q.pop_front());
                    check({t, " R4 accesses"}, int'(access), exp_a_q.pop_front());
                    check({t, " R5 latency"}, cyc - st_q.pop_front(), exp_l_q.pop_front());
                    last_m = int'(match); last_r = int'(rule); last_a = int'(access);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [NR-1:0] v0, v1;
        for (int f = 0; f < NF; f++)
            for (int k = 0; k < 8; k++) model[f][k] = '0;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 match", int'(match), 0);
        check("R1 rule", int'(rule), 0);
        check("R1 access", int'(access), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 unwritten vectors are zero: miss, no fetches
        search(7, 7, "R1 R7 empty tables");

        v0 = '0; v0[0] = 1'b1;            wr(0, 0, v0);
        v1 = '0; v1[7:0] = 8'hFF;         wr(1, 0, v1);
        v0 = '0; v0[3] = 1'b1; v0[45] = 1'b1; wr(0, 1, v0);
        v1 = '0; v1[45] = 1'b1; v1[60] = 1'b1; wr(1, 1, v1);
        v0 = '0; v0[9] = 1'b1; v0[26] = 1'b1; v0[30] = 1'b1; wr(0, 2, v0);
        v1 = '0; v1[10] = 1'b1; v1[30] = 1'b1; wr(1, 2, v1);
        v0 = '0; v0[0] = 1'b1;            wr(0, 3, v0);
        v1 = '0; v1[8] = 1'b1;            wr(1, 3, v1);
        v0 = '0; v1 = '0;
        for (int b = 0; b < NBLK; b++) begin v0[b*BLK] = 1'b1; v1[b*BLK+1] = 1'b1; end
        wr(0, 4, v0); wr(1, 4, v1);
        v0 = '0; v0[63] = 1'b1; v0[62] = 1'b1; wr(0, 5, v0);
        v1 = '0; v1[63] = 1'b1;           wr(1, 5, v1);

        search(0, 0, "R3 hit block0");
        search(1, 1, "R4 hit block5 skipping");
        search(2, 2, "R6 false block then hit");
        search(3, 3, "R7 no candidate");
        search(4, 4, "R6 R7 all candidates false");
        search(5, 5, "R3 rule63");
        search(2, 1, "R7 mixed keys");
        search(1, 0, "R3 mixed keys");

        // R2 overwrite replaces vector and summary
        v1 = '0; v1[0] = 1'b1; wr(1, 3, v1);
        search(3, 3, "R2 after rewrite");
        v1 = '0; v1[61] = 1'b1; wr(1, 1, v1);
        search(1, 1, "R2 old bits gone");

        // R8 start while busy is ignored
        launch(4, 4, "R8 long walk");
        repeat (3) @(negedge clk);
        key = {3'd0, 3'd0};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (12) @(negedge clk);

        // R9 results held while idle
        check("R9 match held", int'(match), last_m);
        check("R9 rule held", int'(rule), last_r);
        check("R9 access held", int'(access), last_a);
        check("R8 idle after", int'(busy), 0);

        search(5, 5, "R9 next start");
        repeat (4) @(negedge clk);
        check("R9 rule held again", int'(rule), 63);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule